// File: doc/BRIEF.md
# PCI Target Claim and Parity Unit

This block is the target-side front end of a 32-bit PCI slave. When a transaction starts, it latches the command and address. It then checks the address against a programmable window and decides whether to claim the cycle.

The block claims in one of two ways:
- **Positive decode:** a memory command that falls inside the window is claimed on the fast timing. DEVSEL# goes low in the clock right after the address clock.
- **Subtractive decode:** any other cycle can be picked up on the slow timing when the block is enabled as the subtractive agent. It does so only if no other device has pulled DEVSEL# low while it waited.

Once it has claimed a cycle, the block answers as an always-ready target:
- TRDY# goes low one clock after DEVSEL#.
- On reads, the block drives the read data onto AD.
- On reads, the block also returns even parity on PAR one clock after each completed data phase.
- When the final data phase ends, the block drives its strobes high for one clock and then releases them.

Every bused output is a value plus its own output-enable. Pad tristating is left to the instance above.

Top module: `pci_tgt_claim`

## Requirements
- R1: While reset is asserted and whenever no cycle is claimed, all four output enables (DEVSEL#, TRDY#, AD, PAR) are low, and DEVSEL# and TRDY# read high.
- R2: A start is the first edge on which FRAME# is sampled low after being sampled high. At that edge, a command of 0110 or 0111 (memory read or write), with AD[31:WIN_LSB] equal to the window base, drives DEVSEL# low with its enable high in the next clock. Address bits below WIN_LSB are ignored.
- R3: A command outside 0110/0111, or a memory command whose upper address bits differ from the base, is not claimed by positive decode. With subtractive mode off, DEVSEL#'s enable stays low for the whole cycle.
- R4: With subtractive mode on and no positive hit, the block watches the external DEVSEL# sense for the three edges after the start. If that sense is high at all three edges, DEVSEL# is driven low from the third of them on.
- R5: If the external DEVSEL# sense is low at any of those three edges, including the third, the block never enables DEVSEL# for that cycle.
- R6: TRDY# goes low one clock after DEVSEL# goes low. Both stay low until the final data phase completes.
- R7: A data phase completes at an edge where IRDY# and TRDY# are both sampled low. It is the final phase if FRAME# is also high. After that edge, DEVSEL# and TRDY# are driven high with their enables on for one clock, and the enables then drop.
- R8: For read commands (command bit 0 equal to 0), the AD enable is high exactly while TRDY# is driven low, and AD carries the read-data input. For write commands the AD enable stays low.
- R9: In the clock after each completed read data phase, the PAR enable is high. PAR then makes the count of ones over AD[31:0], C/BE#[3:0] and PAR, as sampled at that completion, even. PAR is never enabled on writes.
- R10: A FRAME# that is still low when the block returns to idle after a cycle is not taken as a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, byte enables afterwards |
| ad_in | input | 32 | Address/data bus as sampled |
| devsel_in_n | input | 1 | DEVSEL# sensed on the bus from other agents |
| sub_en | input | 1 | Enables subtractive claiming |
| win_base | input | ADDR_W-WIN_LSB | Window base, upper address bits |
| rd_data | input | 32 | Data returned on reads |
| devsel_n | output | 1 | DEVSEL# value |
| devsel_oe | output | 1 | DEVSEL# output enable |
| trdy_n | output | 1 | TRDY# value |
| trdy_oe | output | 1 | TRDY# output enable |
| ad_out | output | 32 | AD value driven on reads |
| ad_oe | output | 1 | AD output enable |
| par_out | output | 1 | PAR value |
| par_oe | output | 1 | PAR output enable |

## Verification
The hardest case to reach from the ports is the subtractive yield at its last edge. There, another agent's DEVSEL# appears on the third edge after the start, the same edge on which the block would otherwise claim. Directed cycles place the external sense at each of the three edges, including that final one. Random cycles also draw the sense position, so that yields mix with wait states and multi-phase bursts.

A second case needs a master that keeps FRAME# low into the idle return. A directed cycle holds FRAME# low with a hitting address right after a final phase, to show that no new start is recognised.

// File: rtl/pci_claim_pkg.sv
`timescale 1ns/1ps
package pci_claim_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_SUBWAIT,
    CS_PASS,
    CS_TURN,
    CS_DATA,
    CS_DROP
  } claim_st_t;

  // memory read 0110 / memory write 0111
  function automatic logic is_mem_cmd(input logic [3:0] cmd);
    return (cmd[3:1] == 3'b011);
  endfunction

  // read-type commands have bit 0 clear
  function automatic logic is_rd_cmd(input logic [3:0] cmd);
    return ~cmd[0];
  endfunction

  // PAR value giving an even count of ones over data, enables and PAR
  function automatic logic even_par(input logic [31:0] d, input logic [3:0] be);
    return ^{d, be};
  endfunction

endpackage

// File: rtl/pci_addr_match.sv
`timescale 1ns/1ps
module pci_addr_match #(
  parameter int ADDR_W  = 32,
  parameter int WIN_LSB = 20,
  localparam int TAG_W  = ADDR_W - WIN_LSB
) (
  input  logic [TAG_W-1:0] addr_tag,
  input  logic [3:0]       cmd,
  input  logic [TAG_W-1:0] base_tag,
  output logic             hit,
  output logic             rd_kind
);
  import pci_claim_pkg::*;

  logic tag_eq;

  assign tag_eq  = (addr_tag == base_tag);
  assign hit     = tag_eq && is_mem_cmd(cmd);
  assign rd_kind = is_rd_cmd(cmd);
endmodule

// File: rtl/pci_claim_seq.sv
`timescale 1ns/1ps
module pci_claim_seq #(
  parameter int SUB_DELAY = 4,
  localparam int CW = (SUB_DELAY > 2) ? $clog2(SUB_DELAY) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic devsel_in_n,
  input  logic sub_en,
  input  logic hit,
  input  logic rd_kind,
  output logic devsel_n,
  output logic devsel_oe,
  output logic trdy_n,
  output logic trdy_oe,
  output logic ad_oe,
  output logic rd_phase_done,
  output logic start_ev,
  output logic fast_claim_ev,
  output logic yield_ev
);
  import pci_claim_pkg::*;

  localparam logic [CW-1:0] LAST_WAIT = CW'(SUB_DELAY - 2);

  claim_st_t      st_q, st_d;
  logic [CW-1:0]  wait_q, wait_d;
  logic           frame_q;
  logic           rd_q, rd_d;
  logic           phase_done;

  assign start_ev      = (st_q == CS_IDLE) && frame_q && !frame_n;
  assign fast_claim_ev = start_ev && hit;
  assign yield_ev      = (st_q == CS_SUBWAIT) && !devsel_in_n;
  assign phase_done    = (st_q == CS_DATA) && !irdy_n;
  assign rd_phase_done = phase_done && rd_q;

  always_comb begin
    st_d   = st_q;
    wait_d = wait_q;
    rd_d   = rd_q;
    unique case (st_q)
      CS_IDLE: begin
        if (start_ev) begin
          rd_d   = rd_kind;
          wait_d = '0;
          if (hit)         st_d = CS_TURN;
          else if (sub_en) st_d = CS_SUBWAIT;
          else             st_d = CS_PASS;
        end
      end
      CS_SUBWAIT: begin
        if (yield_ev)                 st_d = CS_PASS;
        else if (wait_q == LAST_WAIT) st_d = CS_TURN;
        else                          wait_d = wait_q + 1'b1;
      end
      CS_PASS: begin
        if (frame_n && irdy_n) st_d = CS_IDLE;
      end
      CS_TURN: st_d = CS_DATA;
      CS_DATA: begin
        if (phase_done && frame_n) st_d = CS_DROP;
      end
      CS_DROP: st_d = CS_IDLE;
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CS_IDLE;
      wait_q  <= '0;
      frame_q <= 1'b1;
      rd_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      wait_q  <= wait_d;
      frame_q <= frame_n;
      rd_q    <= rd_d;
    end
  end

  // strobes are decoded from the registered state only
  assign devsel_n  = !((st_q == CS_TURN) || (st_q == CS_DATA));
  assign trdy_n    = !(st_q == CS_DATA);
  assign devsel_oe = (st_q == CS_TURN) || (st_q == CS_DATA) || (st_q == CS_DROP);
  assign trdy_oe   = devsel_oe;
  assign ad_oe     = rd_q && (st_q == CS_DATA);
endmodule

// File: rtl/pci_par_gen.sv
`timescale 1ns/1ps
module pci_par_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] ad,
  input  logic [3:0]  cbe_n,
  output logic        par_out,
  output logic        par_oe
);
  import pci_claim_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_out <= 1'b0;
      par_oe  <= 1'b0;
    end else begin
      par_oe <= load;
      if (load) par_out <= even_par(ad, cbe_n);
    end
  end
endmodule

// File: rtl/pci_tgt_claim.sv
`timescale 1ns/1ps
module pci_tgt_claim #(
  parameter int ADDR_W    = 32,
  parameter int WIN_LSB   = 20,
  parameter int SUB_DELAY = 4,
  localparam int TAG_W    = ADDR_W - WIN_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic [3:0]        cbe_n,
  input  logic [ADDR_W-1:0] ad_in,
  input  logic              devsel_in_n,
  input  logic              sub_en,
  input  logic [TAG_W-1:0]  win_base,
  input  logic [ADDR_W-1:0] rd_data,
  output logic              devsel_n,
  output logic              devsel_oe,
  output logic              trdy_n,
  output logic              trdy_oe,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              par_out,
  output logic              par_oe
);
  logic hit, rd_kind, rd_phase_done;
  logic start_ev, fast_claim_ev, yield_ev;

  pci_addr_match #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_match (
    .addr_tag (ad_in[ADDR_W-1:WIN_LSB]),
    .cmd      (cbe_n),
    .base_tag (win_base),
    .hit      (hit),
    .rd_kind  (rd_kind)
  );

  pci_claim_seq #(.SUB_DELAY(SUB_DELAY)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_n       (frame_n),
    .irdy_n        (irdy_n),
    .devsel_in_n   (devsel_in_n),
    .sub_en        (sub_en),
    .hit           (hit),
    .rd_kind       (rd_kind),
    .devsel_n      (devsel_n),
    .devsel_oe     (devsel_oe),
    .trdy_n        (trdy_n),
    .trdy_oe       (trdy_oe),
    .ad_oe         (ad_oe),
    .rd_phase_done (rd_phase_done),
    .start_ev      (start_ev),
    .fast_claim_ev (fast_claim_ev),
    .yield_ev      (yield_ev)
  );

  pci_par_gen u_par (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rd_phase_done),
    .ad      (ad_in[31:0]),
    .cbe_n   (cbe_n),
    .par_out (par_out),
    .par_oe  (par_oe)
  );

  assign ad_out = rd_data;
endmodule

// File: rtl/pci_claim_chk.sv
`timescale 1ns/1ps
module pci_claim_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        devsel_n,
  input logic        devsel_oe,
  input logic        trdy_n,
  input logic        trdy_oe,
  input logic        ad_oe,
  input logic        par_out,
  input logic        par_oe,
  input logic [31:0] ad_in,
  input logic [3:0]  cbe_n,
  input logic        fast_claim_ev,
  input logic        yield_ev
);
  assert_quiet_unclaimed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !devsel_oe |-> (!trdy_oe && !ad_oe && devsel_n && trdy_n));

  assert_fast_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fast_claim_ev |=> (!devsel_n && devsel_oe));

  assert_yield_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    yield_ev |=> !devsel_oe);

  assert_trdy_after_devsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> (!$past(devsel_n) && !devsel_n));

  assert_release_after_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(devsel_n) |=> !devsel_oe);

  assert_ad_only_with_trdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!trdy_n && trdy_oe));

  assert_even_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ((par_out ^ (^$past(ad_in)) ^ (^$past(cbe_n))) == 1'b0));
endmodule

bind pci_tgt_claim pci_claim_chk u_claim_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .devsel_n      (devsel_n),
  .devsel_oe     (devsel_oe),
  .trdy_n        (trdy_n),
  .trdy_oe       (trdy_oe),
  .ad_oe         (ad_oe),
  .par_out       (par_out),
  .par_oe        (par_oe),
  .ad_in         (ad_in[31:0]),
  .cbe_n         (cbe_n),
  .fast_claim_ev (fast_claim_ev),
  .yield_ev      (yield_ev)
);

// File: tb/pci_tgt_claim_test.sv
`timescale 1ns/1ps
module pci_tgt_claim_test;
  localparam int WIN_LSB = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        frame_n = 1'b1, irdy_n = 1'b1, devsel_in_n = 1'b1, sub_en = 1'b0;
  logic [3:0]  cbe_n = 4'hF;
  logic [31:0] ad_in = '0, rd_data = '0;
  logic [11:0] win_base = 12'hA5C;
  logic        devsel_n, devsel_oe, trdy_n, trdy_oe, ad_oe, par_out, par_oe;
  logic [31:0] ad_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  pci_tgt_claim #(.ADDR_W(32), .WIN_LSB(WIN_LSB), .SUB_DELAY(4)) uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n),
    .ad_in(ad_in), .devsel_in_n(devsel_in_n), .sub_en(sub_en), .win_base(win_base),
    .rd_data(rd_data), .devsel_n(devsel_n), .devsel_oe(devsel_oe), .trdy_n(trdy_n),
    .trdy_oe(trdy_oe), .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit b_hit(input logic [31:0] a, input logic [3:0] c);
    return ((c == 4'd6) || (c == 4'd7)) && (a[31:20] == win_base);
  endfunction

  // PAR is 1 exactly when the other 36 bits hold an odd number of ones
  function automatic bit b_par(input logic [31:0] d, input logic [3:0] b);
    int n;
    n = $countones(d) + $countones(b);
    return (n % 2) == 1;
  endfunction

  task automatic run_txn(input logic [31:0] addr, input logic [3:0] cmd, input int nph,
                         input int ext_at, input int wt, input bit hold);
    bit hit, rd, claimed, comp_prev, par_prev, live, ir, exp_oe, exp_tr_n;
    int c_edge, f_edge, done_ph, j;
    string rq;
    hit = b_hit(addr, cmd);
    rd = !cmd[0];
    claimed = hit || (sub_en && (ext_at == 0 || ext_at > 3));
    c_edge = hit ? 0 : 3;
    f_edge = -1;
    done_ph = 0;
    comp_prev = 0;
    par_prev = 0;
    rq = hit ? "R2" : (claimed ? "R4" : ((sub_en && ext_at > 0) ? "R5" : "R3"));
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad_in = addr; cbe_n = cmd; devsel_in_n = 1'b1;
    for (int k = 1; k < 64; k++) begin
      @(negedge clk);
      j = k - 1;
      live     = claimed && j >= c_edge && (f_edge < 0 || j < f_edge);
      exp_oe   = claimed && j >= c_edge && (f_edge < 0 || j <= f_edge);
      exp_tr_n = !(claimed && j >= c_edge + 1 && (f_edge < 0 || j < f_edge));
      if (f_edge >= 0 && j >= f_edge) rq = (j > f_edge + 1) ? "R10" : "R7";
      chk(devsel_n == !live, rq, "devsel_n", devsel_n, !live);
      chk(devsel_oe == exp_oe, rq, "devsel_oe", devsel_oe, exp_oe);
      chk(trdy_n == exp_tr_n, "R6", "trdy_n", trdy_n, exp_tr_n);
      chk(trdy_oe == exp_oe, "R7", "trdy_oe", trdy_oe, exp_oe);
      chk(ad_oe == (rd && !exp_tr_n), "R8", "ad_oe", ad_oe, rd && !exp_tr_n);
      if (ad_oe) chk(ad_out == rd_data, "R8", "ad_out", ad_out, rd_data);
      chk(par_oe == (rd && comp_prev), "R9", "par_oe", par_oe, rd && comp_prev);
      if (rd && comp_prev) chk(par_out == par_prev, "R9", "par_out", par_out, par_prev);
      if (claimed && f_edge >= 0 && j == f_edge + (hold ? 5 : 1)) break;
      if (!claimed && k == 11) break;
      devsel_in_n = !(ext_at > 0 && ext_at < 4 && k >= ext_at);
      comp_prev = 0;
      if (claimed && f_edge >= 0) begin
        if (hold) begin
          frame_n = 1'b0; irdy_n = 1'b1; cbe_n = 4'd6; ad_in = {win_base, 20'h00010};
        end else begin
          frame_n = 1'b1; irdy_n = 1'b1;
        end
      end else if (claimed) begin
        if (k == 1 || (trdy_n == 1'b0 && irdy_n == 1'b0)) begin
          ad_in = $urandom; cbe_n = 4'($urandom); rd_data = $urandom;
        end
        ir = (k <= wt);
        irdy_n = ir;
        frame_n = (!ir && done_ph == nph - 1);
        comp_prev = !ir && (trdy_n == 1'b0);
        par_prev = b_par(ad_in, cbe_n);
        if (comp_prev) begin
          done_ph++;
          if (frame_n) f_edge = k;
        end
      end else begin
        if (k == 1) begin ad_in = $urandom; cbe_n = 4'($urandom); end
        irdy_n = (k <= wt);
        frame_n = 1'b0;
        if (k == 7) begin frame_n = 1'b1; irdy_n = 1'b0; end
        if (k >= 8) begin frame_n = 1'b1; irdy_n = 1'b1; end
      end
    end
    frame_n = 1'b1; irdy_n = 1'b1; devsel_in_n = 1'b1; cbe_n = 4'hF;
    @(negedge clk);
    chk(!devsel_oe && !trdy_oe && !ad_oe, "R1", "idle enables", devsel_oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [3:0]  c;
    void'($urandom(32'h5EED_0123));
    repeat (3) @(negedge clk);
    // R1: reset state, during and after reset
    chk(!devsel_oe && !trdy_oe && !ad_oe && !par_oe, "R1", "oe in reset", devsel_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(devsel_n && trdy_n && !devsel_oe && !par_oe, "R1", "after reset", devsel_n, 1);

    // directed corners
    sub_en = 0; run_txn({win_base, 20'h00040}, 4'd6, 2, 0, 0, 0);   // R2 fast read
    sub_en = 0; run_txn({win_base, 20'hFFFFF}, 4'd7, 3, 0, 1, 0);   // R2 low bits ignored, write
    sub_en = 0; run_txn({win_base ^ 12'h001, 20'h0}, 4'd6, 1, 0, 0, 0); // R3 off by one tag bit
    sub_en = 0; run_txn({win_base, 20'h0}, 4'b1010, 1, 0, 0, 0);   // R3 non-memory cmd
    sub_en = 1; run_txn(32'h0000_1000, 4'b0010, 2, 0, 0, 0);      // R4 subtractive read
    sub_en = 1; run_txn(32'h0000_2000, 4'b0011, 1, 0, 2, 0);      // R4 subtractive write
    sub_en = 1; run_txn(32'h0000_3000, 4'b0010, 1, 1, 0, 0);      // R5 sense at first edge
    sub_en = 1; run_txn(32'h0000_3000, 4'b0010, 1, 3, 0, 0);      // R5 sense at last edge
    sub_en = 0; run_txn({win_base, 20'h00100}, 4'd6, 1, 0, 0, 1); // R10 frame held low

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      c = ($urandom % 3 == 0) ? 4'($urandom) : 4'(6 + ($urandom % 2));
      a = $urandom;
      if ($urandom % 2 == 0) a[31:20] = win_base;
      sub_en = 1'($urandom);
      run_txn(a, c, 1 + int'($urandom % 4), int'($urandom % 4), int'($urandom % 3), 1'($urandom % 8 == 0));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule